// File: doc/BRIEF.md
# Endian-Configurable Byte Lane Steering

This block connects a processor load/store port to a memory that is one 32-bit word wide. The processor issues byte-addressed loads and stores of one, two or four bytes. The block turns each request into a word access. It presents the word index and one write enable per byte lane, and it places the store data in the correct lanes. When the memory returns a word for a load, the block picks out the addressed bytes and zero-extends them to the full width.

A mode input chooses the byte order for each request. In big-endian order, the lowest byte address of a word holds the most significant byte. In little-endian order, the lowest byte address holds the least significant byte. The block checks natural alignment. A misaligned request is not passed to memory. Instead, the block raises an error pulse.

Request outputs are registered and appear one cycle after the request. The block keeps the byte order, size and offset of the last load it issued. When the read data returns, it uses that saved context, so it allows one load in flight at a time. The registered load value appears one cycle after the read data.

Top module: `byte_lane_steer`

## Requirements
- R1: One cycle after a request with `req_valid` high, `mem_index` equals request address bits [31:2] and `mem_write` equals `req_write`, if the request is aligned.
- R2: Size code 0 (byte) enables exactly one lane. The lane is the address offset (address bits [1:0]) in little-endian mode and 3 minus the offset in big-endian mode. Lane i is `mem_wdata[8i+7:8i]`, and it is enabled by `mem_be[i]`.
- R3: Size code 1 (halfword) at offset 0 enables lanes 4'b0011 in little-endian mode and 4'b1100 in big-endian mode. At offset 2 it enables 4'b1100 in little-endian mode and 4'b0011 in big-endian mode. Size code 2 (word) enables 4'b1111.
- R4: Store data is replicated across the lanes: a byte is copied onto all four lanes, a halfword is copied onto both halves, and a word passes through unchanged. This holds in both modes. For example, a little-endian word store of 32'h46789654 puts 8'h54 in lane 0, which is the lowest address.
- R5: A halfword with address bit 0 set, a word with a non-zero offset, and any request with size code 3 are misaligned. One cycle later `misalign_err` is 1, and `mem_valid`, `mem_write` and every `mem_be` bit are 0.
- R6: One cycle after `mem_rvalid`, `ld_valid` is 1 and `ld_data` holds the addressed value, zero-extended. In little-endian mode, value byte k comes from lane offset+k. In big-endian mode, the most significant value byte comes from lane 3 minus the offset.
- R7: The byte order used to extract a load is the mode sampled with the load request, not the mode at the time the data returns.
- R8: While reset is active, all outputs are 0.
- R9: A cycle with `req_valid` low gives `mem_valid`, `mem_write`, `misalign_err` and `mem_be` all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 selects big-endian byte order, 0 selects little-endian |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| mem_valid | output | 1 | Word access to memory |
| mem_write | output | 1 | Word access is a store |
| mem_index | output | 30 | Word index |
| mem_be | output | 4 | Per-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| misalign_err | output | 1 | Misaligned request pulse |
| mem_rvalid | input | 1 | Read word returned |
| mem_rdata | input | 32 | Read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Zero-extended load value |

## Verification
Every request output (index, enables, steered data and error) is due one clock edge after the request is driven. The bench drives each request on a falling edge and reads the outputs on the next falling edge, after exactly one rising edge. Load results are due one edge after `mem_rvalid` and are sampled the same way. The sweep covers both modes, all four size codes, all four offsets and both directions. Expected lanes are computed from the byte address mapping, not from shifts.

// File: rtl/lane_pkg.sv
package lane_pkg;
   localparam int SIZE_W = 2;
   typedef enum logic [SIZE_W-1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;
endpackage

// File: rtl/lane_enable_gen.sv
module lane_enable_gen #(
   parameter int LANES  = 4,
   parameter int OFF_W  = 2,
   parameter int SIZE_W = 2
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic [SIZE_W-1:0] size,
   input  logic              big_endian,
   output logic [LANES-1:0]  lane_en,
   output logic [OFF_W-1:0]  low_mask,
   output logic              misaligned
);
   // low_mask marks the offset bits that lie inside one access
   always_comb begin
      for (int b = 0; b < OFF_W; b++) begin
         low_mask[b] = (b < int'(size));
      end
      misaligned = (int'(size) > OFF_W) || ((offset & low_mask) != '0);
   end

   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         localparam logic [OFF_W-1:0] LE_POS = OFF_W'(i);
         localparam logic [OFF_W-1:0] BE_POS = OFF_W'(LANES - 1 - i);
         logic [OFF_W-1:0] pos;
         assign pos        = big_endian ? BE_POS : LE_POS;
         assign lane_en[i] = !misaligned && ((pos & ~low_mask) == (offset & ~low_mask));
      end
   endgenerate

   // R3: an aligned access always selects at least one lane
   always_comb begin
      if (misaligned == 1'b0) begin
         a_r3_some_lane: assert (lane_en != '0);
      end
   end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract #(
   parameter int LANES  = 4,
   parameter int OFF_W  = 2,
   parameter int SIZE_W = 2
) (
   input  logic [8*LANES-1:0] word,
   input  logic [OFF_W-1:0]   offset,
   input  logic [SIZE_W-1:0]  size,
   input  logic               big_endian,
   output logic [8*LANES-1:0] value
);
   always_comb begin
      int nbytes;
      int low;
      nbytes = 1 << size;
      low    = big_endian ? (LANES - int'(offset) - nbytes) : int'(offset);
      value  = '0;
      for (int k = 0; k < LANES; k++) begin
         if (k < nbytes) begin
            value[8*k +: 8] = word[8*((low + k) & (LANES - 1)) +: 8];
         end
      end
   end
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
   import lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          big_endian,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [SIZE_W-1:0]             req_size,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          mem_valid,
   output logic                          mem_write,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_index,
   output logic [DATA_W/8-1:0]           mem_be,
   output logic [DATA_W-1:0]             mem_wdata,
   output logic                          misalign_err,
   input  logic                          mem_rvalid,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic                          ld_valid,
   output logic [DATA_W-1:0]             ld_data
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   generate
      if (DATA_W % 8 != 0 || LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_width
         $error("byte_lane_steer: DATA_W must be a power-of-two number of bytes, at least 2");
      end
      if (OFF_W + 1 > (1 << SIZE_W)) begin : g_bad_size
         $error("byte_lane_steer: size code too narrow for DATA_W");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("byte_lane_steer: ADDR_W too small");
      end
   endgenerate

   logic [OFF_W-1:0]  req_off;
   logic [LANES-1:0]  lane_en;
   logic [OFF_W-1:0]  low_mask;
   logic              misaligned;
   logic [DATA_W-1:0] steered;

   assign req_off = req_addr[OFF_W-1:0];

   lane_enable_gen #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) i_enable (
      .offset     (req_off),
      .size       (req_size),
      .big_endian (big_endian),
      .lane_en    (lane_en),
      .low_mask   (low_mask),
      .misaligned (misaligned)
   );

   // lane i carries value byte (i mod access bytes): replication in both orders
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         steered[8*i +: 8] = req_wdata[8*(i & int'(low_mask)) +: 8];
      end
   end

   logic [SIZE_W-1:0] size_q;
   logic [OFF_W-1:0]  ctx_off;
   logic [SIZE_W-1:0] ctx_size;
   logic              ctx_big;
   logic [SIZE_W-1:0] ld_size_q;
   logic [DATA_W-1:0] extracted;

   lane_load_extract #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) i_extract (
      .word       (mem_rdata),
      .offset     (ctx_off),
      .size       (ctx_size),
      .big_endian (ctx_big),
      .value      (extracted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid    <= 1'b0;
         mem_write    <= 1'b0;
         mem_index    <= '0;
         mem_be       <= '0;
         mem_wdata    <= '0;
         misalign_err <= 1'b0;
         size_q       <= '0;
         ctx_off      <= '0;
         ctx_size     <= '0;
         ctx_big      <= 1'b0;
         ld_valid     <= 1'b0;
         ld_data      <= '0;
         ld_size_q    <= '0;
      end else begin
         mem_valid    <= req_valid && !misaligned;
         mem_write    <= req_valid && req_write && !misaligned;
         misalign_err <= req_valid && misaligned;
         mem_be       <= req_valid ? lane_en : '0;
         if (req_valid) begin
            mem_index <= req_addr[ADDR_W-1:OFF_W];
            mem_wdata <= steered;
            size_q    <= req_size;
         end
         if (req_valid && !req_write && !misaligned) begin
            ctx_off  <= req_off;
            ctx_size <= req_size;
            ctx_big  <= big_endian;
         end
         ld_valid <= mem_rvalid;
         if (mem_rvalid) begin
            ld_data   <= extracted;
            ld_size_q <= ctx_size;
         end
      end
   end

   a_r1_index: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_index == $past(req_addr[ADDR_W-1:OFF_W]));
   a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> $countones(mem_be) == (1 << size_q));
   a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> (mem_be == '0 && !mem_valid && !mem_write));
   a_r6_ld_follow: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |=> ld_valid);
   a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_size_q == SZ_BYTE) |-> ld_data[DATA_W-1:8] == '0);
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!mem_valid && !misalign_err && mem_be == '0));
endmodule

// File: tb/test_byte_lane_steer.sv
module test_byte_lane_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_valid, mem_write, misalign_err, ld_valid;
   logic [29:0] mem_index;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, ld_data;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   byte_lane_steer i_byte_lane_steer (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_index(mem_index),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .misalign_err(misalign_err),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .ld_valid(ld_valid), .ld_data(ld_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int lane_of(input logic be, input int a);
      return be ? 3 - a : a;
   endfunction

   // one request; outputs sampled one rising edge later
   task automatic do_req(input logic be, input logic wr, input int sz, input int off,
                         input logic [31:0] wd);
      int n;
      logic bad;
      logic [3:0]  exp_be;
      logic [31:0] exp_wd;
      logic [31:0] addr;
      addr = 32'h0001_2340 + 32'(off);
      @(negedge clk);
      big_endian = be; req_valid = 1'b1; req_write = wr;
      req_size = 2'(sz); req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      n   = 1 << sz;
      bad = (sz == 3) || (sz == 1 && off[0]) || (sz == 2 && off != 0);
      exp_be = '0;
      if (!bad) for (int k = 0; k < n; k++) exp_be[lane_of(be, off + k)] = 1'b1;
      exp_wd = (n == 1) ? {4{wd[7:0]}} : (n == 2) ? {2{wd[15:0]}} : wd;
      chk("R5 misalign_err", 32'(misalign_err), 32'(bad));
      chk("R5 mem_valid", 32'(mem_valid), 32'(!bad));
      chk(sz == 0 ? "R2 byte enables" : "R3 enables", 32'(mem_be), 32'(exp_be));
      if (!bad) begin
         chk("R1 index", 32'(mem_index), 32'(addr >> 2));
         chk("R1 write", 32'(mem_write), 32'(wr));
         if (wr) chk("R4 store data", mem_wdata, exp_wd);
      end else begin
         chk("R5 write suppressed", 32'(mem_write), 32'd0);
      end
   endtask

   task automatic do_load(input logic be_req, input logic be_ret, input int sz, input int off,
                          input logic [31:0] rd);
      int n;
      logic [31:0] exp_v;
      do_req(be_req, 1'b0, sz, off, 32'h0);
      @(negedge clk);
      big_endian = be_ret; mem_rvalid = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_rvalid = 1'b0;
      n = 1 << sz;
      exp_v = '0;
      for (int k = 0; k < n; k++) begin
         exp_v[8*(be_req ? n - 1 - k : k) +: 8] = rd[8*lane_of(be_req, off + k) +: 8];
      end
      chk("R6 ld_valid", 32'(ld_valid), 32'd1);
      chk(be_req != be_ret ? "R7 load mode" : "R6 load data", ld_data, exp_v);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 mem_valid", 32'(mem_valid), 32'd0);
      chk("R8 mem_be", 32'(mem_be), 32'd0);
      chk("R8 err", 32'(misalign_err), 32'd0);
      chk("R8 ld_valid", 32'(ld_valid), 32'd0);
      chk("R8 ld_data", ld_data, 32'd0);
      chk("R8 mem_wdata", mem_wdata, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: idle cycle after reset
      chk("R9 idle valid", 32'(mem_valid), 32'd0);
      chk("R9 idle be", 32'(mem_be), 32'd0);

      // R4: little-endian word example, lowest address lane holds 8'h54
      do_req(1'b0, 1'b1, 2, 0, 32'h4678_9654);
      chk("R4 lane0 byte", 32'(mem_wdata[7:0]), 32'h54);
      chk("R4 lane3 byte", 32'(mem_wdata[31:24]), 32'h46);

      for (int be = 0; be < 2; be++)
         for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++) begin
               do_req(1'(be), 1'b1, sz, off, 32'hA1B2_C3D4 ^ 32'(off * 32'h0101_0101 + sz));
               if (!((sz == 3) || (sz == 1 && off % 2 == 1) || (sz == 2 && off != 0)))
                  do_load(1'(be), 1'(be), sz, off, 32'h8E3C_5A71 + 32'(off * 32'h1020_3040));
               else
                  do_req(1'(be), 1'b0, sz, off, 32'h0);
            end

      // R9: idle after traffic
      @(negedge clk);
      chk("R9 idle valid", 32'(mem_valid), 32'd0);
      chk("R9 idle err", 32'(misalign_err), 32'd0);

      // R7: mode flipped between request and data return
      do_load(1'b1, 1'b0, 1, 0, 32'hDEAD_BEEF);
      do_load(1'b0, 1'b1, 0, 1, 32'hDEAD_BEEF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule